// File: doc/BRIEF.md
# Busy Status Read Responder

This block sits in the read path of a sector-programmed flash array. While the internal program timer is running, it substitutes end-of-cycle status for parts of the word handed back to the host. When the timer finishes, it steps aside and the array word passes through unchanged.

Two independent status methods are provided in every byte lane of the word:

- **Polling bit.** The top bit of each lane is returned inverted whenever the host reads the address it wrote last.
- **Toggle bit.** The bit just below the polling bit flips once for every new read access while the cycle is busy.

Host software may use either method, starting at any point during the cycle. The read strobe is the host's combined read-access qualifier. The block samples it on the system clock and counts each low-to-high change as one new access. The output word is formed combinationally from the inputs and one toggle register, so a change in the busy input appears on the read data in the same clock cycle.

Top module: `busy_status_responder`

## Requirements
- R1: While `busy` is low, `rd_data` equals `arr_data` on every bit.
- R2: While `busy` is high and `rd_addr` equals `last_addr`, bit 8k+7 of `rd_data` is the inverse of bit 8k+7 of `last_data`, for every byte lane k.
- R3: While `busy` is high, bit 8k+6 of `rd_data` holds the same value in every byte lane k.
- R4: While `busy` is high, the toggle bits (bit 8k+6) are inverted in the clock cycle after a clock edge at which `rd_strobe` is sampled high, provided it was sampled low at the edge before. Two successive read accesses therefore never show the same toggle value.
- R5: While `busy` is high, the toggle bits keep their value from one cycle to the next when no new strobe rise has been sampled, whether `rd_strobe` is held high or held low.
- R6: While `busy` is high, every bit other than 8k+6 and 8k+7 comes from `last_data` when `rd_addr` equals `last_addr`. When the addresses differ, these bits and bit 8k+7 come from `arr_data`.
- R7: After a synchronous reset, the toggle state is 0. A busy read made before any strobe rise returns 0 on the toggle bits.
- R8: Strobe rises while `busy` is low leave the toggle state unchanged. When `busy` returns, the toggle bits show the value they had when `busy` last fell.
- R9: A change of `busy` takes effect on `rd_data` within the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Read access qualifier; each sampled rise is a new read |
| busy | input | 1 | Internal program cycle in progress |
| rd_addr | input | ADDR_W | Address of the current read |
| last_addr | input | ADDR_W | Address of the last word loaded for programming |
| last_data | input | DATA_W | Last word loaded for programming |
| arr_data | input | DATA_W | Word read from the array at `rd_addr` |
| rd_data | output | DATA_W | Word returned to the host |

## Verification
The only internal state is the toggle register and the registered copy of the strobe. A wrong value in either shows on bits 8k+6 of the first busy read after it occurs. A missed edge or a double flip shows as two successive busy reads with equal toggle bits, one cycle after the strobe rise. A toggle register that is disturbed while idle shows on the first busy cycle after `busy` returns. Polling and pass-through faults have no state behind them, so they appear in the same cycle as the input pattern that exercises them.

// File: rtl/busy_status_pkg.sv
package busy_status_pkg;
  localparam int LANE_W   = 8;
  localparam int POLL_POS = 7;
  localparam int TOGL_POS = 6;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/toggle_state.sv
module toggle_state (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rise,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst)              tog <= 1'b0;
    else if (busy && rise) tog <= ~tog;
  end
endmodule

// File: rtl/status_mux.sv
module status_mux
  import busy_status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              busy,
  input  logic              tog,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LANES = DATA_W / LANE_W;

  logic              hit;
  logic [DATA_W-1:0] base;

  assign hit  = busy && (rd_addr == last_addr);
  assign base = hit ? last_data : arr_data;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      if (b == POLL_POS) begin : g_poll
        assign rd_data[k*LANE_W+b] = hit ? ~base[k*LANE_W+b] : base[k*LANE_W+b];
      end else if (b == TOGL_POS) begin : g_togl
        assign rd_data[k*LANE_W+b] = busy ? tog : base[k*LANE_W+b];
      end else begin : g_pass
        assign rd_data[k*LANE_W+b] = base[k*LANE_W+b];
      end
    end
  end
endmodule

// File: rtl/busy_status_responder.sv
module busy_status_responder #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic rise;
  logic tog;

  strobe_rise u_rise (
    .clk    (clk),
    .rst    (rst),
    .strobe (rd_strobe),
    .rise   (rise)
  );

  toggle_state u_tog (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .rise (rise),
    .tog  (tog)
  );

  status_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .busy      (busy),
    .tog       (tog),
    .rd_addr   (rd_addr),
    .last_addr (last_addr),
    .last_data (last_data),
    .arr_data  (arr_data),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/busy_status_checker.sv
module busy_status_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              busy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] rd_data
);
  localparam int TOP_T = DATA_W - 2;
  localparam int TOP_P = DATA_W - 1;

  logic [1:0] age;
  logic       settled;

  always_ff @(posedge clk) begin
    if (rst)             age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  assign settled = (age == 2'd2);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> rd_data == arr_data); // R1

  AST_POLL_INVERT: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_addr == last_addr) |->
      (rd_data[7] != last_data[7]) && (rd_data[TOP_P] != last_data[TOP_P])); // R2

  AST_TOGGLE_LANES: assert property (@(posedge clk) disable iff (rst)
    busy |-> rd_data[6] == rd_data[TOP_T]); // R3

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (settled && busy && $past(busy) && $past(rd_strobe) && !$past(rd_strobe, 2))
      |-> rd_data[6] != $past(rd_data[6])); // R4

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (settled && busy && $past(busy) && !($past(rd_strobe) && !$past(rd_strobe, 2)))
      |-> $stable(rd_data[6])); // R5
endmodule

bind busy_status_responder busy_status_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_strobe (rd_strobe),
  .busy      (busy),
  .rd_addr   (rd_addr),
  .last_addr (last_addr),
  .last_data (last_data),
  .arr_data  (arr_data),
  .rd_data   (rd_data)
);

// File: tb/test_busy_status_responder.sv
module test_busy_status_responder;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_strobe = 1'b0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [AW-1:0] last_addr = 16'h0001;
  logic [DW-1:0] last_data = '0;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit m_tog = 1'b0;
  bit m_prev = 1'b0;
  bit saved_tog;

  always #5 clk = ~clk;

  busy_status_responder #(.DATA_W(DW), .ADDR_W(AW)) i_busy_status_responder (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .busy(busy),
    .rd_addr(rd_addr), .last_addr(last_addr), .last_data(last_data),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] model_out();
    logic [DW-1:0] e;
    bit hit = busy && (rd_addr == last_addr);
    for (int i = 0; i < DW; i++) begin
      int pos = i % 8;
      if (!busy)          e[i] = arr_data[i];
      else if (pos == 6)  e[i] = m_tog;
      else if (hit)       e[i] = (pos == 7) ? ~last_data[i] : last_data[i];
      else                e[i] = arr_data[i];
    end
    return e;
  endfunction

  // reference model of the toggle state
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_tog = 1'b0;
      m_prev = 1'b0;
    end else begin
      if (busy && rd_strobe && !m_prev) m_tog = !m_tog;
      m_prev = rd_strobe;
    end
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (!busy) check("R1 model", rd_data, model_out());
      else       check("R2/R3/R4/R6 model", rd_data, model_out());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    arr_data = 16'h1234;
    tick(1);
    check("R1 idle pass-through", rd_data, 16'h1234);

    busy = 1'b1; arr_data = 16'h0000; rd_addr = 16'h0010;
    tick(1);
    check("R7 toggle zero after reset", rd_data, 16'h0000);

    rd_strobe = 1'b1;
    tick(1);
    check("R4 first rise flips toggle", rd_data, 16'h4040);
    check("R3 toggle equal in both lanes", {15'd0, rd_data[6]}, {15'd0, rd_data[14]});
    tick(3);
    check("R5 strobe held high keeps toggle", rd_data, 16'h4040);
    rd_strobe = 1'b0;
    tick(3);
    check("R5 strobe held low keeps toggle", rd_data, 16'h4040);
    rd_strobe = 1'b1;
    tick(1);
    check("R4 second rise flips back", rd_data, 16'h0000);
    rd_strobe = 1'b0;
    tick(1);
    rd_strobe = 1'b1;
    tick(1);

    last_addr = 16'h0010; last_data = 16'hA5C3; arr_data = 16'h0F0F;
    tick(1);
    check("R2 R6 polling on last loaded word", rd_data, 16'h6543);
    rd_addr = 16'h0011;
    tick(1);
    check("R6 other address reads array", rd_data, 16'h4F4F);

    busy = 1'b0; arr_data = 16'hBEEF;
    #1;
    check("R9 busy drop shows true data same cycle", rd_data, 16'hBEEF);

    for (int p = 0; p < 3; p++) begin
      rd_strobe = 1'b0; tick(1);
      rd_strobe = 1'b1; tick(1);
    end
    rd_strobe = 1'b0;
    tick(1);
    check("R1 idle strobes pass array", rd_data, 16'hBEEF);
    busy = 1'b1; arr_data = 16'h0000;
    #1;
    check("R8 toggle kept across idle", rd_data, 16'h4040);

    for (int i = 0; i < 600; i++) begin
      saved_tog = m_tog;
      rd_strobe = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) busy = ~busy;
      rd_addr   = ($urandom_range(0, 1) == 1) ? last_addr : 16'($urandom);
      arr_data  = 16'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        last_addr = 16'($urandom);
        last_data = 16'($urandom);
      end
      tick(1);
      if (busy && !saved_tog && m_tog)
        check("R4 random rise", {15'd0, rd_data[6]}, 16'd1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule